// File: doc/BRIEF.md
# Alarm Match and Interrupt Pin Controller

This block decides when a timekeeping subsystem should signal its host. It holds four alarm bytes: seconds, minutes, hours and day of month. Each byte carries an ignore bit in its most significant position. On every 1 Hz tick the stored values are compared with the current BCD time. A successful comparison raises a sticky alarm flag. Watchdog-timeout, power-fail and year-rollover event pulses raise their own sticky flags. All four flags sit in one status byte, and that byte is cleared by a complete read of it.

A control byte selects which flags may drive the single interrupt output and how the output behaves. The output can be push-pull active high or open-drain active low. It can follow the flags as a level, or fire as a one-shot pulse timed in 32 Hz ticks. A flag read cuts a running pulse short. While the block runs from backup power, only the alarm may act on the pin, and then only through the open-drain pull-down. The analog voltage comparators sit outside the block. The block only passes them a threshold-select bit.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: An alarm field takes part in the comparison when bit 7 of its byte is 0. The field is ignored when bit 7 is 1. The compared fields are seconds (offset 2), minutes (3), hours (4) and date (5), using bits 6:0. When a 1 Hz tick arrives and every included field equals the current time, the alarm flag is set on that clock edge.
- R2: The mask bits combine freely. With every field ignored, each tick sets the alarm flag. With seconds and minutes included and the other two ignored, the hours and date values have no effect.
- R3: The status byte at offset 0 reads as watchdog flag (bit 7), alarm flag (bit 6), power-fail flag (bit 5) and century flag (bit 4). Bits 3:0 read 0. A watchdog, power-fail or century event pulse sets its flag, and every flag stays set until it is cleared.
- R4: An access is the span of consecutive cycles with `acc_en` high, and its offset is taken in its first cycle. A read access of offset 0 clears all four flags on the edge where `acc_en` is first seen low. An access that contains any cycle with `acc_we` high clears nothing. An event arriving on the clearing edge keeps its flag set.
- R5: After reset the control byte at offset 1 reads 24h, the alarm bytes read 00h and the flags are clear. Control bits from MSB to LSB are: watchdog enable, alarm enable, power-fail enable, alarm-in-backup enable, polarity high, pulse mode, threshold select, spare. `pf_thresh_hi` follows bit 1.
- R6: Outside backup, a flag whose enable bit is set requests the pin. In level mode (bit 2 = 0) the pin is active from the edge that sets the flag until the clearing edge of R4.
- R7: In pulse mode, the pin turns active on the clock edge after the request rises. It stays active for PULSE_TICKS pulses of `tick_32hz`. A flag clear ends it at once. A request that stays high gives only one pulse.
- R8: When not in backup, polarity bit 3 = 1 drives an active pin on `irq_drive_hi`, and bit 3 = 0 drives it on `irq_pull_lo`. The two outputs are never high together.
- R9: With `backup_mode` high, only the alarm flag can request the pin, and only when both alarm enable and alarm-in-backup enable are set. An active pin then always uses `irq_pull_lo`, and `irq_drive_hi` stays low.
- R10: Writes to offset 0 leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse when the seconds count advances |
| tick_32hz | input | 1 | One-cycle pulse at 32 Hz for pulse timing |
| time_sec | input | 7 | Current seconds, BCD |
| time_min | input | 7 | Current minutes, BCD |
| time_hour | input | 7 | Current hours, BCD |
| time_date | input | 7 | Current day of month, BCD |
| wdog_evt | input | 1 | Watchdog timeout pulse |
| pf_evt | input | 1 | Power-fail pulse |
| cen_evt | input | 1 | Year rollover pulse |
| backup_mode | input | 1 | High while running from backup supply |
| acc_en | input | 1 | Register access in progress |
| acc_we | input | 1 | Write strobe during an access |
| acc_addr | input | 3 | Register offset |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for `acc_addr` |
| irq_pull_lo | output | 1 | Open-drain pull-down enable (active-low pin) |
| irq_drive_hi | output | 1 | Push-pull high drive (active-high pin) |
| pf_thresh_hi | output | 1 | Power-fail threshold select to the comparator |

## Verification
The bench builds the block with the default PULSE_TICKS of 6. It drives the 32 Hz tick itself, so a full one-shot window and a pulse cut short by a read each take only tens of cycles. With both tick inputs driven directly, every mask combination, every polarity and backup case, and a read that carries a write strobe can all be reached in a short run. The bench also runs a behavioural model in step with the design and compares the read data and both pin outputs on every clock.

// File: rtl/irq_ctrl_pkg.sv
// Shared constants and types for the alarm/interrupt controller.
// Assumes an 8-bit register bus and 7-bit BCD time fields.
package irq_ctrl_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int TIME_W   = 7;
    localparam int N_FIELDS = 4;   // sec, min, hour, date
    localparam int N_FLAGS  = 4;   // wdog, alarm, pfail, century

    localparam logic [ADDR_W-1:0] ADR_FLAG  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CTL   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_ALARM = 3'd2;  // first of four alarm bytes

    // index of each flag within the flag vector (MSB first on the bus)
    localparam int FL_WDOG = 3;
    localparam int FL_ALRM = 2;
    localparam int FL_PF   = 1;
    localparam int FL_CEN  = 0;

    localparam logic [DATA_W-1:0] CTL_RESET = 8'h24;

    typedef struct packed {
        logic wdog_en;
        logic alarm_en;
        logic pf_en;
        logic alarm_bk_en;
        logic pol_hi;
        logic pulse_mode;
        logic thr_hi;
        logic spare;
    } irq_ctl_t;
endpackage

// File: rtl/irq_alarm_match.sv
// Masked comparison of the four alarm bytes against the current time.
// Assumes time fields are stable in the cycle the 1 Hz tick is high.
module irq_alarm_match
    import irq_ctrl_pkg::*;
(
    input  logic                                    tick_1hz,
    input  logic [N_FIELDS-1:0][DATA_W-1:0]         alarm_bytes,
    input  logic [N_FIELDS-1:0][TIME_W-1:0]         now,
    output logic                                    alarm_hit
);
    logic [N_FIELDS-1:0] field_ok;

    // one comparator per field: mask bit in the MSB bypasses the compare
    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        assign field_ok[g] = alarm_bytes[g][DATA_W-1]
                           | (alarm_bytes[g][TIME_W-1:0] == now[g]);
    end

    // a hit is only reported on the tick
    assign alarm_hit = tick_1hz & (&field_ok);
endmodule

// File: rtl/irq_regs.sv
// Register bank: control byte, alarm bytes, sticky flags with read-clear.
// Assumes the offset is steady across an access; the clear is decided at its end.
module irq_regs
    import irq_ctrl_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              acc_en,
    input  logic                              acc_we,
    input  logic [ADDR_W-1:0]                 acc_addr,
    input  logic [DATA_W-1:0]                 acc_wdata,
    output logic [DATA_W-1:0]                 acc_rdata,
    input  logic                              wdog_evt,
    input  logic                              pf_evt,
    input  logic                              cen_evt,
    input  logic                              alarm_hit,
    output irq_ctl_t                          ctl,
    output logic [N_FIELDS-1:0][DATA_W-1:0]   alarm_bytes,
    output logic [N_FLAGS-1:0]                flags,
    output logic                              flag_clr
);
    logic acc_q;
    logic rd_flag_pend;
    logic we_seen;
    logic [N_FLAGS-1:0] evt_vec;

    // track one access: offset taken at its start, write strobes accumulated
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q        <= 1'b0;
            rd_flag_pend <= 1'b0;
            we_seen      <= 1'b0;
        end else begin
            acc_q <= acc_en;
            if (acc_en && !acc_q) begin
                rd_flag_pend <= (acc_addr == ADR_FLAG);
                we_seen      <= acc_we;
            end else if (acc_en) begin
                we_seen <= we_seen | acc_we;
            end
        end
    end

    assign flag_clr = acc_q && !acc_en && rd_flag_pend && !we_seen;

    // writable bytes: control and alarms; flag offset is read-only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl         <= irq_ctl_t'(CTL_RESET);
            alarm_bytes <= '0;
        end else if (acc_en && acc_we) begin
            if (acc_addr == ADR_CTL)
                ctl <= irq_ctl_t'(acc_wdata);
            for (int i = 0; i < N_FIELDS; i++)
                if (acc_addr == ADR_ALARM + ADDR_W'(i))
                    alarm_bytes[i] <= acc_wdata;
        end
    end

    always_comb begin
        evt_vec          = '0;
        evt_vec[FL_WDOG] = wdog_evt;
        evt_vec[FL_ALRM] = alarm_hit;
        evt_vec[FL_PF]   = pf_evt;
        evt_vec[FL_CEN]  = cen_evt;
    end

    // sticky flags; a new event on the clearing edge survives
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flag_clr ? '0 : flags) | evt_vec;
    end

    // read mux
    always_comb begin
        acc_rdata = '0;
        if (acc_addr == ADR_FLAG)
            acc_rdata = {flags, {(DATA_W-N_FLAGS){1'b0}}};
        else if (acc_addr == ADR_CTL)
            acc_rdata = ctl;
        for (int i = 0; i < N_FIELDS; i++)
            if (acc_addr == ADR_ALARM + ADDR_W'(i))
                acc_rdata = alarm_bytes[i];
    end
endmodule

// File: rtl/irq_pin_drv.sv
// Interrupt pin driver: source gating, level/one-shot timing, polarity.
// Assumes tick_32hz is a single-cycle pulse; pulse width is PULSE_TICKS of it.
module irq_pin_drv
    import irq_ctrl_pkg::*;
#(
    parameter int PULSE_TICKS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_32hz,
    input  logic                 backup_mode,
    input  logic [N_FLAGS-1:0]   flags,
    input  logic                 flag_clr,
    input  logic                 wdog_en,
    input  logic                 alarm_en,
    input  logic                 pf_en,
    input  logic                 alarm_bk_en,
    input  logic                 pol_hi,
    input  logic                 pulse_mode,
    output logic                 irq_pull_lo,
    output logic                 irq_drive_hi
);
    localparam int CNT_W = $clog2(PULSE_TICKS + 1);

    logic             req;
    logic             req_q;
    logic [CNT_W-1:0] cnt;
    logic             active;

    // source gating; in backup only the alarm with its backup enable
    always_comb begin
        if (backup_mode)
            req = flags[FL_ALRM] & alarm_en & alarm_bk_en;
        else
            req = (flags[FL_WDOG] & wdog_en)
                | (flags[FL_ALRM] & alarm_en)
                | (flags[FL_PF]   & pf_en);
    end

    // one-shot counter: loaded on request rise, cut by a flag clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            cnt   <= '0;
        end else begin
            req_q <= req;
            if (flag_clr)
                cnt <= '0;
            else if (req && !req_q)
                cnt <= CNT_W'(PULSE_TICKS);
            else if (tick_32hz && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    // pad control
    assign active       = pulse_mode ? (cnt != '0) : req;
    assign irq_pull_lo  = active & (backup_mode | !pol_hi);
    assign irq_drive_hi = active & !backup_mode & pol_hi;
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Top of the alarm-match and interrupt-pin controller.
// Assumes all inputs are synchronous to clk; ticks are one-cycle pulses.
module rtc_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int PULSE_TICKS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              tick_32hz,
    input  logic [6:0]        time_sec,
    input  logic [6:0]        time_min,
    input  logic [6:0]        time_hour,
    input  logic [6:0]        time_date,
    input  logic              wdog_evt,
    input  logic              pf_evt,
    input  logic              cen_evt,
    input  logic              backup_mode,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [2:0]        acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic              irq_pull_lo,
    output logic              irq_drive_hi,
    output logic              pf_thresh_hi
);
    irq_ctl_t                            ctl;
    logic [N_FIELDS-1:0][DATA_W-1:0]     alarm_bytes;
    logic [N_FIELDS-1:0][TIME_W-1:0]     now;
    logic [N_FLAGS-1:0]                  flags;
    logic                                flag_clr;
    logic                                alarm_hit;

    assign now          = {time_date, time_hour, time_min, time_sec};
    assign pf_thresh_hi = ctl.thr_hi;

    irq_alarm_match u_match (
        .tick_1hz    (tick_1hz),
        .alarm_bytes (alarm_bytes),
        .now         (now),
        .alarm_hit   (alarm_hit)
    );

    irq_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_en      (acc_en),
        .acc_we      (acc_we),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .acc_rdata   (acc_rdata),
        .wdog_evt    (wdog_evt),
        .pf_evt      (pf_evt),
        .cen_evt     (cen_evt),
        .alarm_hit   (alarm_hit),
        .ctl         (ctl),
        .alarm_bytes (alarm_bytes),
        .flags       (flags),
        .flag_clr    (flag_clr)
    );

    irq_pin_drv #(.PULSE_TICKS(PULSE_TICKS)) u_pin (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_32hz    (tick_32hz),
        .backup_mode  (backup_mode),
        .flags        (flags),
        .flag_clr     (flag_clr),
        .wdog_en      (ctl.wdog_en),
        .alarm_en     (ctl.alarm_en),
        .pf_en        (ctl.pf_en),
        .alarm_bk_en  (ctl.alarm_bk_en),
        .pol_hi       (ctl.pol_hi),
        .pulse_mode   (ctl.pulse_mode),
        .irq_pull_lo  (irq_pull_lo),
        .irq_drive_hi (irq_drive_hi)
    );
endmodule

// File: rtl/irq_ctrl_chk.sv
// Property checker for rtc_irq_ctrl, attached by bind below.
// Assumes it sees the top's internal flag vector, clear strobe and alarm hit.
module irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       backup_mode,
    input logic       tick_1hz,
    input logic       wdog_evt,
    input logic       pf_evt,
    input logic       cen_evt,
    input logic       irq_pull_lo,
    input logic       irq_drive_hi,
    input logic       flag_clr,
    input logic [3:0] flags,
    input logic       alarm_hit
);
    logic quiet;
    assign quiet = !tick_1hz && !wdog_evt && !pf_evt && !cen_evt;

    a_r1_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> flags[2]);

    a_r3_wdog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[3] && !flag_clr) |=> flags[3]);

    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && quiet) |=> (flags == 4'b0000));

    a_r6_release_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && quiet) |=> (!irq_pull_lo && !irq_drive_hi));

    a_r8_exclusive_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pull_lo && irq_drive_hi));

    a_r9_no_high_in_backup: assert property (@(posedge clk) disable iff (!rst_n)
        backup_mode |-> !irq_drive_hi);
endmodule

bind rtc_irq_ctrl irq_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .backup_mode  (backup_mode),
    .tick_1hz     (tick_1hz),
    .wdog_evt     (wdog_evt),
    .pf_evt       (pf_evt),
    .cen_evt      (cen_evt),
    .irq_pull_lo  (irq_pull_lo),
    .irq_drive_hi (irq_drive_hi),
    .flag_clr     (flag_clr),
    .flags        (flags),
    .alarm_hit    (alarm_hit)
);

// File: tb/rtc_irq_ctrl_tb_top.sv
module rtc_irq_ctrl_tb_top;
    localparam int P = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1hz = 0, tick_32hz = 0;
    logic [6:0] time_sec = 7'h01, time_min = 7'h02, time_hour = 7'h03, time_date = 7'h04;
    logic wdog_evt = 0, pf_evt = 0, cen_evt = 0, backup_mode = 0;
    logic acc_en = 0, acc_we = 0;
    logic [2:0] acc_addr = 3'd7;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] acc_rdata;
    logic irq_pull_lo, irq_drive_hi, pf_thresh_hi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rtc_irq_ctrl #(.PULSE_TICKS(P)) dut_i (.*);

    // ---------------- behavioural reference model ----------------
    int  m_wdf, m_af, m_pf, m_cf;
    int  m_ctl;
    int  m_al[4];
    int  m_cnt, m_reqq, m_accq, m_pend, m_wes;

    function automatic int m_req();
        int c = m_ctl;
        if (backup_mode) return m_af && c[6] && c[4];
        return (m_wdf && c[7]) || (m_af && c[6]) || (m_pf && c[5]);
    endfunction

    function automatic int m_active();
        return m_ctl[2] ? (m_cnt != 0) : m_req();
    endfunction

    function automatic int m_rdata(input int a);
        if (a == 0) return (m_wdf << 7) | (m_af << 6) | (m_pf << 5) | (m_cf << 4);
        if (a == 1) return m_ctl;
        if (a >= 2 && a <= 5) return m_al[a-2];
        return 0;
    endfunction

    function automatic int fld_ok(input int al, input int t);
        return al[7] || ((al & 'h7f) == t);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wdf = 0; m_af = 0; m_pf = 0; m_cf = 0; m_ctl = 'h24;
            foreach (m_al[i]) m_al[i] = 0;
            m_cnt = 0; m_reqq = 0; m_accq = 0; m_pend = 0; m_wes = 0;
        end else begin
            int clr, hit, req, cur_cnt;
            clr = m_accq && !acc_en && m_pend && !m_wes;
            hit = tick_1hz && fld_ok(m_al[0], time_sec) && fld_ok(m_al[1], time_min)
                  && fld_ok(m_al[2], time_hour) && fld_ok(m_al[3], time_date);
            req = m_req();
            cur_cnt = m_cnt;
            if (clr) m_cnt = 0;
            else if (req && !m_reqq) m_cnt = P;
            else if (tick_32hz && cur_cnt != 0) m_cnt = cur_cnt - 1;
            m_reqq = req;
            if (clr) begin m_wdf = 0; m_af = 0; m_pf = 0; m_cf = 0; end
            if (wdog_evt) m_wdf = 1;
            if (hit) m_af = 1;
            if (pf_evt) m_pf = 1;
            if (cen_evt) m_cf = 1;
            if (acc_en && acc_we) begin
                if (acc_addr == 1) m_ctl = acc_wdata;
                if (acc_addr >= 2 && acc_addr <= 5) m_al[acc_addr-2] = acc_wdata;
            end
            if (acc_en && !m_accq) begin m_pend = (acc_addr == 0); m_wes = acc_we; end
            else if (acc_en) m_wes = m_wes | acc_we;
            m_accq = acc_en;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison after both model and design have settled
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            int act, pl, dh;
            act = m_active();
            pl = act && (backup_mode || !m_ctl[3]);
            dh = act && !backup_mode && m_ctl[3];
            chk(acc_rdata == 8'(m_rdata(acc_addr)), "R3 rdata vs model", acc_rdata, m_rdata(acc_addr));
            chk(irq_pull_lo == pl, "R6 pull_lo vs model", irq_pull_lo, pl);
            chk(irq_drive_hi == dh, "R8 drive_hi vs model", irq_drive_hi, dh);
            chk(pf_thresh_hi == m_ctl[1], "R5 threshold select", pf_thresh_hi, m_ctl[1]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); acc_en = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
        @(negedge clk); acc_en = 0; acc_we = 0; acc_addr = 3'd7;
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input bit strobe, output logic [7:0] v);
        @(negedge clk); acc_en = 1; acc_we = 0; acc_addr = a;
        #1 v = acc_rdata;
        if (strobe) begin @(negedge clk); acc_we = 1; acc_wdata = 8'hff; end
        @(negedge clk); acc_en = 0; acc_we = 0; acc_addr = 3'd7;
        @(negedge clk);
    endtask

    task automatic peek_flags(output logic [7:0] v);
        acc_addr = 3'd0; #1 v = acc_rdata; acc_addr = 3'd7;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: tick_1hz = 1; 1: tick_32hz = 1; 2: wdog_evt = 1;
            3: pf_evt = 1;   default: cen_evt = 1;
        endcase
        @(negedge clk);
        tick_1hz = 0; tick_32hz = 0; wdog_evt = 0; pf_evt = 0; cen_evt = 0;
    endtask

    function automatic logic [1:0] pins();
        return {irq_pull_lo, irq_drive_hi};
    endfunction

    task automatic set_time(input logic [6:0] d, h, m, s);
        time_date = d; time_hour = h; time_min = m; time_sec = s;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R5: reset values
        acc_addr = 3'd1; #1 chk(acc_rdata == 8'h24, "R5 ctl reset", acc_rdata, 8'h24);
        acc_addr = 3'd2; #1 chk(acc_rdata == 8'h00, "R5 alarm reset", acc_rdata, 8'h00);
        peek_flags(v); chk(v == 8'h00, "R5 flags reset", v, 8'h00);
        chk(pins() == 2'b00, "R5 pin idle", pins(), 0);

        // R1: seconds-only alarm, level mode, active low
        wr(3'd1, 8'h40);
        wr(3'd2, 8'h15); wr(3'd3, 8'h80); wr(3'd4, 8'h80); wr(3'd5, 8'h80);
        set_time(7'h04, 7'h03, 7'h02, 7'h14); pulse(0);
        peek_flags(v); chk(v == 8'h00, "R1 no match", v, 8'h00);
        set_time(7'h04, 7'h03, 7'h02, 7'h15); pulse(0);
        peek_flags(v); chk(v == 8'h40, "R1 seconds match", v, 8'h40);
        chk(pins() == 2'b10, "R6 level active low", pins(), 2);
        repeat (4) @(negedge clk);
        chk(pins() == 2'b10, "R6 level holds", pins(), 2);
        rd(3'd0, 0, v); chk(v == 8'h40, "R3 read shows alarm flag", v, 8'h40);
        chk(pins() == 2'b00, "R6 released after read", pins(), 0);
        peek_flags(v); chk(v == 8'h00, "R4 read cleared", v, 8'h00);

        // R2: all masked fires every tick
        wr(3'd2, 8'h80);
        set_time(7'h11, 7'h22, 7'h33, 7'h44); pulse(0);
        peek_flags(v); chk(v == 8'h40, "R2 all masked", v, 8'h40);
        rd(3'd0, 0, v);
        // R2: sec+min included, hour/date ignored
        wr(3'd2, 8'h30); wr(3'd3, 8'h45);
        set_time(7'h01, 7'h12, 7'h45, 7'h30); pulse(0);
        peek_flags(v); chk(v == 8'h40, "R2 hourly match", v, 8'h40);
        rd(3'd0, 0, v);
        set_time(7'h09, 7'h13, 7'h45, 7'h30); pulse(0);
        peek_flags(v); chk(v == 8'h40, "R2 hour ignored", v, 8'h40);
        rd(3'd0, 0, v);
        set_time(7'h09, 7'h13, 7'h44, 7'h30); pulse(0);
        peek_flags(v); chk(v == 8'h00, "R2 minute mismatch", v, 8'h00);
        // R1: full date match
        wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h08); wr(3'd5, 8'h17);
        set_time(7'h18, 7'h08, 7'h00, 7'h00); pulse(0);
        peek_flags(v); chk(v == 8'h00, "R1 date mismatch", v, 8'h00);
        set_time(7'h17, 7'h08, 7'h00, 7'h00); pulse(0);
        peek_flags(v); chk(v == 8'h40, "R1 full match", v, 8'h40);

        // R4: read with a write strobe clears nothing; R10: flag write ignored
        rd(3'd0, 1, v);
        peek_flags(v); chk(v == 8'h40, "R4 strobe blocks clear", v, 8'h40);
        wr(3'd0, 8'h00);
        peek_flags(v); chk(v == 8'h40, "R10 flag write ignored", v, 8'h40);
        rd(3'd0, 0, v);

        // R3: other flags set without enables; no pin
        wr(3'd1, 8'h02);
        pulse(4); pulse(3); pulse(2);
        peek_flags(v); chk(v == 8'hb0, "R3 wdog pf century flags", v, 8'hb0);
        chk(pins() == 2'b00, "R6 disabled sources", pins(), 0);
        chk(pf_thresh_hi == 1'b1, "R5 threshold bit", pf_thresh_hi, 1);
        rd(3'd0, 0, v);

        // R7: pulse mode full width
        wr(3'd1, 8'h84);
        pulse(2);
        @(negedge clk);
        chk(pins() == 2'b10, "R7 pulse starts", pins(), 2);
        for (int i = 0; i < P - 1; i++) pulse(1);
        chk(pins() == 2'b10, "R7 active before last tick", pins(), 2);
        pulse(1);
        chk(pins() == 2'b00, "R7 ends after PULSE_TICKS", pins(), 0);
        peek_flags(v); chk(v == 8'h80, "R3 flag stays after pulse", v, 8'h80);
        rd(3'd0, 0, v);
        // R7: read cuts pulse short
        pulse(3); wr(3'd1, 8'ha4); pulse(2);
        @(negedge clk);
        pulse(1); pulse(1);
        chk(pins() == 2'b10, "R7 mid pulse", pins(), 2);
        rd(3'd0, 0, v);
        chk(pins() == 2'b00, "R7 read ends pulse", pins(), 0);

        // R8: active-high level
        wr(3'd1, 8'h88);
        pulse(2);
        chk(pins() == 2'b01, "R8 push-pull high", pins(), 1);
        rd(3'd0, 0, v);

        // R9: backup behaviour
        wr(3'd1, 8'hd8); wr(3'd2, 8'h80); wr(3'd3, 8'h80); wr(3'd4, 8'h80); wr(3'd5, 8'h80);
        @(negedge clk); backup_mode = 1;
        pulse(2);
        chk(pins() == 2'b00, "R9 wdog silent in backup", pins(), 0);
        pulse(0);
        chk(pins() == 2'b10, "R9 alarm low in backup", pins(), 2);
        rd(3'd0, 0, v);
        wr(3'd1, 8'hc8);
        pulse(0);
        chk(pins() == 2'b00, "R9 no backup enable", pins(), 0);
        @(negedge clk); backup_mode = 0;
        #1 chk(pins() == 2'b01, "R8 main power high drive", pins(), 1);
        rd(3'd0, 0, v);
        repeat (3) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule